// File: doc/BRIEF.md
# Two-Class Prioritized Interrupt Collector

This block gathers a set of peripheral interrupt lines (32 by default) into a latched source register. Each latched source is gated by two independent enable masks. The masks sort the sources into a normal class and a fast class. Each class has its own pending vector.

From those vectors the block raises one request line per class toward the processor core. The fast class always takes precedence over the normal class. The block also computes a find-first-one index for each class, with the most significant bit treated as the highest priority. In addition it gives a byte offset, derived from the fast index, that software can use to pick a 4-byte entry in a handler table.

A small register bus reads every register. Through the same bus, software writes the two enable masks and clears latched sources with write-one-to-clear writes.

Top module: `irq_hub`

## Requirements
- R1: A source line that is high at a rising clock edge sets its bit in the source register at that edge. The bit stays set after the line falls. The source register reads at bus address 0.
- R2: A bus write to address 0 clears every source bit whose write-data bit is 1. Write-data bits of 0 leave their source bits unchanged. A bit whose line is high in the same cycle as the clear stays set.
- R3: The normal enable mask is read and written at address 1, and the fast enable mask at address 2.
- R4: The normal pending vector reads at address 3 and equals source AND normal enable. The fast pending vector reads at address 4 and equals source AND fast enable. Bus writes to addresses 3 and 4 change nothing.
- R5: The fast index output is N-1-k, where k is the highest set bit of the fast pending vector. It is N when that vector is empty, so with N=8 bit 7 gives 0 and bit 0 alone gives 7. It is combinational from the registers.
- R6: The normal index output follows the same rule, applied to the normal pending vector.
- R7: The fast request output is high exactly when any fast pending bit is set.
- R8: The normal request output is high exactly when any normal pending bit is set and no fast pending bit is set.
- R9: The dispatch offset output equals the fast index multiplied by 4.
- R10: Synchronous active-low reset clears the sources and both masks. After reset both requests are low and both indices read N.
- R11: Reads of addresses 5 to 7 return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| irq_in | input | NUM_SRC | Peripheral interrupt lines |
| bus_wr | input | 1 | Write strobe for the register bus |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | NUM_SRC | Write data |
| bus_rdata | output | NUM_SRC | Combinational read data for bus_addr |
| req_norm | output | 1 | Normal-class request to the core |
| req_fast | output | 1 | Fast-class request to the core |
| ffo_norm | output | $clog2(NUM_SRC+1) | Priority index of the normal pending vector |
| ffo_fast | output | $clog2(NUM_SRC+1) | Priority index of the fast pending vector |
| disp_ofs | output | $clog2(NUM_SRC+1)+2 | Fast index times 4, a handler table byte offset |

## Verification
The bench builds the block with NUM_SRC=8. At that size every one of the 256 source patterns can be latched and checked under four pairs of enable masks. The mask pairs include all-ones, all-zero and interleaved pairs. This brings every index value from 0 to 8 into reach in both classes, along with every overlap of fast and normal pending bits that decides whether the normal request yields. Directed cases then cover a partial clear, a clear racing a held line, writes to read-only addresses, unmapped reads and a reset in mid-run.

// File: rtl/irq_hub_pkg.sv
// Shared definitions for the interrupt collector: register bus width and
// the address of each register. Assumes a word-wide, single-cycle bus.
package irq_hub_pkg;
    localparam int unsigned REG_AW = 3;

    typedef enum logic [REG_AW-1:0] {
        RG_SRC  = 3'd0,
        RG_NEN  = 3'd1,
        RG_FEN  = 3'd2,
        RG_NPND = 3'd3,
        RG_FPND = 3'd4
    } reg_sel_e;
endpackage

// File: rtl/irq_src_latch.sv
// Source capture register. Each bit is set by its line and held until a
// write-one-to-clear; a line that is still high wins over the clear.
// Assumes the lines are already synchronous to clk.
module irq_src_latch #(
    parameter int unsigned N = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] irq_in,
    input  logic [N-1:0] clr_vec,
    output logic [N-1:0] src_q
);
    // Latch new requests, drop cleared ones, and reset to empty.
    always_ff @(posedge clk) begin
        if (!rst_n) src_q <= '0;
        else        src_q <= (src_q & ~clr_vec) | irq_in;
    end

    // R1
    set_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (((src_q & $past(irq_in)) == $past(irq_in)) &&
                          ((src_q & $past(src_q) & ~$past(clr_vec)) ==
                           ($past(src_q) & ~$past(clr_vec)))));

    // R2
    w1c_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> ((src_q & $past(clr_vec) & ~$past(irq_in)) == '0));
endmodule

// File: rtl/irq_ffo.sv
// Priority index of a vector, MSB first: the top bit gives 0, bit 0 alone
// gives N-1, an empty vector gives N. Purely combinational.
module irq_ffo #(
    parameter int unsigned N  = 32,
    parameter int unsigned IW = $clog2(N+1)
) (
    input  logic [N-1:0]  vec,
    output logic [IW-1:0] res
);
    // Scan upward so the highest set bit is the last to write the result.
    always_comb begin
        res = IW'(N);
        for (int i = 0; i < N; i++) begin
            if (vec[i]) res = IW'(N - 1 - i);
        end
    end
endmodule

// File: rtl/irq_hub.sv
// Two-class interrupt collector: latched sources, normal and fast enable
// masks, pending vectors, priority indices, class requests and a table
// offset for the fast class. Assumes a single-cycle register bus with
// combinational read data.
module irq_hub
    import irq_hub_pkg::*;
#(
    parameter int unsigned NUM_SRC = 32,
    localparam int unsigned IDX_W  = $clog2(NUM_SRC + 1),
    localparam int unsigned OFS_W  = IDX_W + 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] irq_in,
    input  logic               bus_wr,
    input  logic [REG_AW-1:0]  bus_addr,
    input  logic [NUM_SRC-1:0] bus_wdata,
    output logic [NUM_SRC-1:0] bus_rdata,
    output logic               req_norm,
    output logic               req_fast,
    output logic [IDX_W-1:0]   ffo_norm,
    output logic [IDX_W-1:0]   ffo_fast,
    output logic [OFS_W-1:0]   disp_ofs
);
    logic [NUM_SRC-1:0] src_q, en_norm_q, en_fast_q, npend, fpend, clr_vec;
    logic [NUM_SRC-1:0] pend_vec [2];
    logic [IDX_W-1:0]   ffo_vec  [2];
    reg_sel_e           sel;

    assign sel = reg_sel_e'(bus_addr);

    // Decode a write-one-to-clear toward the source register.
    always_comb begin
        clr_vec = '0;
        if (bus_wr && sel == RG_SRC) clr_vec = bus_wdata;
    end

    irq_src_latch #(.N(NUM_SRC)) u_src (
        .clk     (clk),
        .rst_n   (rst_n),
        .irq_in  (irq_in),
        .clr_vec (clr_vec),
        .src_q   (src_q)
    );

    // Hold the two enable masks, written over the bus.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_norm_q <= '0;
            en_fast_q <= '0;
        end else if (bus_wr) begin
            if (sel == RG_NEN) en_norm_q <= bus_wdata;
            if (sel == RG_FEN) en_fast_q <= bus_wdata;
        end
    end

    assign npend       = src_q & en_norm_q;
    assign fpend       = src_q & en_fast_q;
    assign pend_vec[0] = npend;
    assign pend_vec[1] = fpend;

    // One priority encoder per class.
    for (genvar c = 0; c < 2; c++) begin : g_cls
        irq_ffo #(.N(NUM_SRC), .IW(IDX_W)) u_ffo (
            .vec (pend_vec[c]),
            .res (ffo_vec[c])
        );
    end

    assign ffo_norm = ffo_vec[0];
    assign ffo_fast = ffo_vec[1];
    assign disp_ofs = {ffo_fast, 2'b00};
    assign req_fast = |fpend;
    assign req_norm = (|npend) & ~req_fast;

    // Return the addressed register, zero for unmapped addresses.
    always_comb begin
        case (sel)
            RG_SRC:  bus_rdata = src_q;
            RG_NEN:  bus_rdata = en_norm_q;
            RG_FEN:  bus_rdata = en_fast_q;
            RG_NPND: bus_rdata = npend;
            RG_FPND: bus_rdata = fpend;
            default: bus_rdata = '0;
        endcase
    end

    // R10
    rst_clear_chk: assert property (@(posedge clk)
        !rst_n |=> (en_norm_q == '0 && en_fast_q == '0 && src_q == '0 &&
                    !req_fast && !req_norm));

    // R8
    norm_yield_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_fast |-> !req_norm);

    // R7
    fast_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_fast == (int'(ffo_fast) != NUM_SRC));

    // R5
    ffo_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(ffo_fast) < NUM_SRC) |->
            (fpend[NUM_SRC - 1 - int'(ffo_fast)] &&
             ((fpend >> (NUM_SRC - int'(ffo_fast))) == '0)));

    // R6
    ffo_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(ffo_norm) == NUM_SRC) |-> (npend == '0));
endmodule

// File: tb/irq_hub_bench.sv
module irq_hub_bench;
    localparam int N      = 8;
    localparam int IW     = $clog2(N + 1);
    localparam int CLK_PD = 10;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [N-1:0]  irq_in = '0;
    logic          bus_wr = 1'b0;
    logic [2:0]    bus_addr = '0;
    logic [N-1:0]  bus_wdata = '0;
    logic [N-1:0]  bus_rdata;
    logic          req_norm, req_fast;
    logic [IW-1:0] ffo_norm, ffo_fast;
    logic [IW+1:0] disp_ofs;

    int n_chk = 0;
    int n_bad = 0;

    always #(CLK_PD/2) clk = ~clk;

    irq_hub #(.NUM_SRC(N)) u_irq_hub (
        .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .req_norm(req_norm), .req_fast(req_fast), .ffo_norm(ffo_norm),
        .ffo_fast(ffo_fast), .disp_ofs(disp_ofs)
    );

    function automatic int exp_ffo(logic [N-1:0] v);
        for (int i = N - 1; i >= 0; i--) if (v[i]) return N - 1 - i;
        return N;
    endfunction

    task automatic chk(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic cyc();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr(int a, int d);
        bus_addr = 3'(a); bus_wdata = N'(d); bus_wr = 1'b1;
        cyc();
        bus_wr = 1'b0;
    endtask

    task automatic rd(int a, output int d);
        bus_addr = 3'(a);
        #1;
        d = int'(bus_rdata);
    endtask

    task automatic pulse(int p);
        irq_in = N'(p);
        cyc();
        irq_in = '0;
    endtask

    task automatic check_all(string tag, int src, int nen, int fen);
        int d, np, fp, ef;
        np = src & nen; fp = src & fen;
        rd(0, d); chk({tag, " R1 src"}, d, src);
        rd(3, d); chk({tag, " R4 npend"}, d, np);
        rd(4, d); chk({tag, " R4 fpend"}, d, fp);
        ef = exp_ffo(N'(fp));
        chk({tag, " R5 ffo_fast"}, int'(ffo_fast), ef);
        chk({tag, " R6 ffo_norm"}, int'(ffo_norm), exp_ffo(N'(np)));
        chk({tag, " R7 req_fast"}, int'(req_fast), int'(fp != 0));
        chk({tag, " R8 req_norm"}, int'(req_norm), int'(np != 0 && fp == 0));
        chk({tag, " R9 disp_ofs"}, int'(disp_ofs), ef * 4);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual=expired expected=done");
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        int d;
        int nen_tab [4] = '{'hFF, 'hF0, 'h5A, 'h00};
        int fen_tab [4] = '{'hFF, 'h0F, 'hA5, 'h00};
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R10 reset state
        check_all("reset R10", 0, 0, 0);
        rd(1, d); chk("R10 nen", d, 0);
        rd(2, d); chk("R10 fen", d, 0);
        chk("R10 ffo_fast", int'(ffo_fast), N);

        // Sweep all patterns under four mask pairs
        for (int m = 0; m < 4; m++) begin
            wr(1, nen_tab[m]); wr(2, fen_tab[m]);
            rd(1, d); chk("R3 nen readback", d, nen_tab[m]);
            rd(2, d); chk("R3 fen readback", d, fen_tab[m]);
            for (int s = 0; s < 256; s++) begin
                pulse(s);
                check_all("sweep", s, nen_tab[m], fen_tab[m]);
                wr(0, 'hFF);
                rd(0, d); chk("R2 clear all", d, 0);
            end
        end

        // R2 partial clear and clear racing a held line
        wr(1, 'h0F); wr(2, 'hF0);
        pulse('hF3);
        wr(0, 'h30);
        rd(0, d); chk("R2 partial clear", d, 'hC3);
        check_all("R2 after", 'hC3, 'h0F, 'hF0);
        wr(0, 'hFF);
        irq_in = 8'h01;
        wr(0, 'hFF);
        rd(0, d); chk("R2 held line survives", d, 'h01);
        irq_in = '0;
        wr(0, 'hFF);
        rd(0, d); chk("R2 cleared once line drops", d, 0);

        // R4 writes to pending addresses ignored
        pulse('h81);
        wr(3, 'h00); wr(4, 'h00);
        check_all("R4 ro", 'h81, 'h0F, 'hF0);
        rd(1, d); chk("R4 nen untouched", d, 'h0F);
        rd(2, d); chk("R4 fen untouched", d, 'hF0);

        // R11 unmapped reads
        for (int a = 5; a < 8; a++) begin
            rd(a, d); chk("R11 unmapped", d, 0);
        end

        // R10 reset in mid-run
        rst_n = 1'b0;
        cyc();
        rst_n = 1'b1;
        check_all("midreset R10", 0, 0, 0);
        rd(1, d); chk("R10 nen cleared", d, 0);
        rd(2, d); chk("R10 fen cleared", d, 0);

        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule